// File: doc/BRIEF.md
# DRAM Same-Page Hit Detector

This block tells the DRAM timing logic whether a new bus access falls in the same DRAM row as the access before it. When it does, the row-strobe cycle can be skipped and the column access can start at once. The block keeps the address of the last valid bus cycle. It compares each new address with that stored value, looking only at the bits a programmable page mask selects.

The hit flag is active low and combinational. It is valid in the same cycle that the address-valid strobe is high. Detection runs only while the enable bit is set. A transfer of bus ownership suppresses the hit for the next bus cycle, because the stored address then belongs to a different master. While detection is off, the stored address is marked invalid, so the first access after detection is turned back on always reports a miss.

Top module: `page_hit_detect`

## Requirements
- R1: After reset, samePageN is high. The first valid access after reset reports no hit (samePageN = 1).
- R2: With detection enabled and a valid stored address, samePageN goes low (0 = hit) in the same cycle as addrValid when `((busAddr ^ stored) & pageMask) == 0`.
- R3: A difference in any bit where pageMask is 1 gives a miss (samePageN = 1). Differences in bits where pageMask is 0 are ignored.
- R4: The page size follows pageMask as it is presented on each access. The same address pair can hit under one mask and miss under another.
- R5: While detectEn is 0, samePageN stays high. The first valid access after detectEn returns to 1 reports no hit.
- R6: The first valid access in the same cycle as, or after, an ownerChange pulse reports no hit. The valid access after that one can hit again.
- R7: The stored address is updated on every valid access while detection is enabled. This includes misses and suppressed accesses.
- R8: samePageN is high in any cycle where addrValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Address of the current bus cycle |
| addrValid | input | 1 | High for one cycle per bus access |
| pageMask | input | 32 | Bits that define the DRAM page (1 = compared) |
| detectEn | input | 1 | Same-page detection enable |
| ownerChange | input | 1 | Pulse when bus control passes to another master |
| samePageN | output | 1 | Active-low page-hit flag, valid with addrValid |

## Verification
A wrong stored address shows up on the very next valid access. It appears either as a false hit on an address from another row, or as a missing hit on a repeated address, so each scenario uses pairs of accesses. A stale valid bit or a stuck suppression flag also shows within one access: the bench re-enables detection, or pulses ownerChange, and then checks one access that must miss, followed by one that must hit again. Unmasked-bit differences and mask changes are tested with addresses that differ only in a single field.

// File: rtl/page_hit_pkg.sv
package page_hit_pkg;
  parameter int ADDR_W = 32;

  typedef struct packed {
    logic loadPrev;
    logic clearPrev;
  } hitStrobes_t;
endpackage

// File: rtl/page_hit_datapath.sv
module page_hit_datapath
  import page_hit_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [AW-1:0] busAddr,
  input  logic [AW-1:0] pageMask,
  input  hitStrobes_t strobes,
  output logic        addrMatch
);
  logic [AW-1:0] prevAddr;
  logic [AW-1:0] diffBits;

  always_ff @(posedge clk) begin
    if (!rstN)                  prevAddr <= '0;
    else if (strobes.clearPrev) prevAddr <= '0;
    else if (strobes.loadPrev)  prevAddr <= busAddr;
  end

  assign diffBits  = (busAddr ^ prevAddr) & pageMask;
  assign addrMatch = (diffBits == '0);

  // R7
  prev_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPrev |=> (prevAddr == $past(busAddr)));
endmodule

// File: rtl/page_hit_ctrl.sv
module page_hit_ctrl
  import page_hit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic        detectEn,
  input  logic        ownerChange,
  input  logic        addrMatch,
  output hitStrobes_t strobes,
  output logic        samePageN
);
  logic prevValid;
  logic suppressPending;
  logic suppressNow;
  logic hitNow;

  assign suppressNow = suppressPending | ownerChange;
  assign strobes.loadPrev  = addrValid & detectEn;
  assign strobes.clearPrev = ~detectEn;

  assign hitNow    = addrValid & detectEn & prevValid & ~suppressNow & addrMatch;
  assign samePageN = ~hitNow;

  always_ff @(posedge clk) begin
    if (!rstN)          prevValid <= 1'b0;
    else if (!detectEn) prevValid <= 1'b0;
    else if (addrValid) prevValid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          suppressPending <= 1'b0;
    else if (addrValid) suppressPending <= 1'b0;
    else if (ownerChange) suppressPending <= 1'b1;
  end

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> samePageN);

  // R5
  disabled_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !detectEn |-> samePageN);

  // R5
  reenable_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!detectEn) && addrValid) |-> samePageN);

  // R6
  owner_same_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ownerChange |-> samePageN);

  // R6
  owner_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ownerChange) && !$past(addrValid) && addrValid) |-> samePageN);
endmodule

// File: rtl/page_hit_detect.sv
module page_hit_detect
  import page_hit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic        addrValid,
  input  logic [31:0] pageMask,
  input  logic        detectEn,
  input  logic        ownerChange,
  output logic        samePageN
);
  hitStrobes_t strobes;
  logic        addrMatch;

  page_hit_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrValid  (addrValid),
    .detectEn   (detectEn),
    .ownerChange(ownerChange),
    .addrMatch  (addrMatch),
    .strobes    (strobes),
    .samePageN  (samePageN)
  );

  page_hit_datapath #(.AW(32)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .pageMask (pageMask),
    .strobes  (strobes),
    .addrMatch(addrMatch)
  );
endmodule

// File: tb/page_hit_detect_tb.sv
module page_hit_detect_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        addrValid = 1'b0;
  logic [31:0] pageMask = 32'hFFFF_F000;
  logic        detectEn = 1'b1;
  logic        ownerChange = 1'b0;
  logic        samePageN;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  page_hit_detect u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .addrValid(addrValid),
    .pageMask(pageMask), .detectEn(detectEn), .ownerChange(ownerChange),
    .samePageN(samePageN)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: samePageN=%b expected %b", tag, act, exp);
    end
  endtask

  // one bus access; output checked in the same cycle, before the edge
  task automatic access(input logic [31:0] a, input logic own, input logic exp,
                        input string tag);
    @(negedge clk);
    busAddr = a; addrValid = 1'b1; ownerChange = own;
    #1 check(samePageN, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addrValid = 1'b0; ownerChange = 1'b0;
    end
  endtask

  task automatic test_reset();
    #1 check(samePageN, 1'b1, "R1 during reset");
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1 check(samePageN, 1'b1, "R1 idle after reset");
    access(32'h1000_0100, 0, 1'b1, "R1 first access misses");
    access(32'h1000_0100, 0, 1'b0, "R2 repeat hits");
    idle(1);
  endtask

  task automatic test_mask();
    pageMask = 32'hFFFF_F000;
    access(32'h1000_0FFC, 0, 1'b0, "R3 unmasked bits ignored");
    access(32'h1000_1000, 0, 1'b1, "R3 masked bit differs");
    access(32'h1000_1000, 0, 1'b0, "R7 miss updated store");
    pageMask = 32'hFFFF_0000;
    access(32'h1000_5000, 0, 1'b0, "R4 wide page hits");
    pageMask = 32'hFFFF_F000;
    access(32'h1000_1000, 0, 1'b1, "R4 narrow page misses");
    idle(1);
  endtask

  task automatic test_idle();
    @(negedge clk);
    busAddr = 32'h1000_1000; addrValid = 1'b0;
    #1 check(samePageN, 1'b1, "R8 matching addr without valid");
    idle(1);
  endtask

  task automatic test_disable();
    @(negedge clk) detectEn = 1'b0;
    access(32'h1000_1000, 0, 1'b1, "R5 disabled no hit");
    idle(1);
    detectEn = 1'b1;
    access(32'h1000_1000, 0, 1'b1, "R5 first after re-enable");
    access(32'h1000_1000, 0, 1'b0, "R5 hit resumes");
    idle(1);
  endtask

  task automatic test_owner();
    @(negedge clk) ownerChange = 1'b1;
    idle(2);
    access(32'h1000_1000, 0, 1'b1, "R6 suppressed after transfer");
    access(32'h1000_1000, 0, 1'b0, "R6 hit after suppressed cycle");
    access(32'h1000_1000, 1, 1'b1, "R6 same-cycle transfer");
    access(32'h1000_1000, 0, 1'b0, "R6 hit following");
    idle(1);
    @(negedge clk) ownerChange = 1'b1;
    access(32'h2000_0000, 0, 1'b1, "R6 suppressed new row");
    access(32'h2000_0004, 0, 1'b0, "R7 suppressed access stored");
    idle(1);
  endtask

  initial begin
    test_reset();
    test_mask();
    test_idle();
    test_disable();
    test_owner();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule